// File: doc/BRIEF.md
# Memory Bus Cycle Controller with Peripheral Wait

This block runs the memory-side machine cycles of a small processor. It works on a 20-bit address bus and a 16-bit data bus that moves only whole words. An external step sequencer walks each cycle through three one-hot steps. The first step places the address. The second opens the source onto the bus. The third makes the destination latch the data. The controller turns each step into bus strobes and into the side effects that end a cycle: a PC increment after an operand fetch, and an instruction-register clear after an execute access.

A memory-mapped peripheral that is not ready holds the WAIT line. The controller does not insert single wait states. When WAIT is seen inside the sampling window, the rest of that cycle loses its strobes and side effects, and the controller asks the sequencer to restart the whole cycle from the first step. Because each rerun starts clean, a cycle that an interrupt cut off simply starts again. If the peripheral is still busy, the rerun waits again.

The controller also holds a 20-bit operand register, which also serves as the address for execute accesses. There is no separate address register. A wide operand fetch merges the 4-bit nibble carried in the opcode above the fetched 16-bit word. A narrow operand fetch zero-extends the word.

Top module: `mcyc_bus_ctrl`

## Requirements
- R1: While `rstN` is low and right after it, `operand` is 0 and `busRd`, `busWr`, `pcInc`, `irClear` and `repeatCycle` are all low.
- R2: For the fetch kinds (`kind` 00 narrow, 01 wide), `busAddr` equals `pcAddr`. For the execute kinds (10 read, 11 write), `busAddr` equals `operand`.
- R3: For kinds 00, 01 and 10, `busRd` is high in the open step (`stepOh[1]`) and in the take step (`stepOh[2]`) when no WAIT has been seen in the cycle. It is never high in the point step (`stepOh[0]`).
- R4: A kind 01 cycle that is not waited loads `operand` with {`opNibble`, `rdData`} at the end of its take step, and it pulses `pcInc` during that step.
- R5: A kind 00 cycle that is not waited loads `operand` with `rdData` zero-extended to 20 bits, and it pulses `pcInc` during the take step.
- R6: For a read kind, WAIT high in the open or take step drops `busRd` from that step to the end of the cycle. In the take step it then raises `repeatCycle` and holds `pcInc` and `irClear` low, and `operand` keeps its value.
- R7: For kind 11, `busWr` is high only in the open step, and only when WAIT is low in that step. WAIT high there means no write in that cycle, `repeatCycle` high in the take step, and no `irClear`.
- R8: A kind 10 or 11 cycle that is not waited pulses `irClear` in its take step. It never pulses `pcInc`, and it leaves `operand` unchanged.
- R9: A new point step forgets any WAIT seen in an earlier cycle, so a rerun with WAIT low completes normally.
- R10: WAIT has no effect outside the sampling window. That means the point step for every kind, and the take step of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepOh | input | 3 | One-hot step: bit0 point, bit1 open, bit2 take; all zero when idle |
| kind | input | 2 | Cycle kind: 00 narrow fetch, 01 wide fetch, 10 execute read, 11 execute write |
| pcAddr | input | 20 | Program counter value used as the fetch address |
| opNibble | input | 4 | Upper operand nibble taken from the opcode |
| rdData | input | 16 | Word read from the data bus |
| waitLine | input | 1 | Peripheral WAIT, high while not ready |
| busAddr | output | 20 | Address bus |
| busRd | output | 1 | Read strobe that opens the addressed source |
| busWr | output | 1 | Write strobe to the addressed destination |
| pcInc | output | 1 | PC increment pulse at a completed fetch |
| irClear | output | 1 | Instruction register clear at a completed execute access |
| repeatCycle | output | 1 | Restart request to the step sequencer after a waited cycle |
| operand | output | 20 | Operand register contents |

## Verification
The hardest case is a cycle whose WAIT arrives late. The strobe has already risen in the open step and must then be withdrawn in the take step. The same cycle must also be followed by a rerun that has to complete without any memory of the earlier wait. The stimulus reaches this by driving WAIT separately in each step of each cycle. It chains waited cycles back to back with different data words, so a stale load or a sticky wait flag shows up in `operand` and in the restart pulse. It also raises WAIT in steps where it must be ignored, to show those steps have no effect.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH16 = 2'b00,
    KIND_FETCH20 = 2'b01,
    KIND_READ    = 2'b10,
    KIND_WRITE   = 2'b11
  } cycKind_e;

  typedef struct packed {
    logic loadOperand;
    logic mergeNibble;
    logic selOperand;
  } dpStrobe_t;
endpackage

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] stepOh,
  input  cycKind_e   kind,
  input  logic       waitLine,
  output dpStrobe_t  strobes,
  output logic       busRd,
  output logic       busWr,
  output logic       pcInc,
  output logic       irClear,
  output logic       repeatCycle
);
  logic stallSeen;
  logic isFetch;
  logic isRead;
  logic inWindow;
  logic waitedNow;

  always_comb begin
    isFetch   = (kind == KIND_FETCH16) || (kind == KIND_FETCH20);
    isRead    = (kind != KIND_WRITE);
    inWindow  = isRead ? (stepOh[1] | stepOh[2]) : stepOh[1];
    waitedNow = stallSeen | (inWindow & waitLine);

    busRd       = isRead & (stepOh[1] | stepOh[2]) & ~waitedNow;
    busWr       = ~isRead & stepOh[1] & ~waitedNow;
    pcInc       = stepOh[2] & isFetch & ~waitedNow;
    irClear     = stepOh[2] & ~isFetch & ~waitedNow;
    repeatCycle = stepOh[2] & waitedNow;

    strobes.loadOperand = stepOh[2] & isFetch & ~waitedNow;
    strobes.mergeNibble = (kind == KIND_FETCH20);
    strobes.selOperand  = ~isFetch;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      stallSeen <= 1'b0;
    else if (stepOh[0])             stallSeen <= 1'b0;
    else if (stepOh[1] | stepOh[2]) stallSeen <= waitedNow;
  end

  assert_rd_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> !stepOh[0] && !busWr);

  assert_rd_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stepOh[2] && isRead && $past(stepOh[1] && isRead && waitLine)) |-> !busRd && repeatCycle);

  assert_repeat_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    repeatCycle |-> !pcInc && !irClear && !strobes.loadOperand);

  assert_wr_open_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> stepOh[1] && !waitLine);

  assert_clear_no_inc_R8: assert property (@(posedge clk) disable iff (!rstN)
    irClear |-> !pcInc);
endmodule

// File: rtl/mcyc_dp.sv
module mcyc_dp
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [ADDR_W-DATA_W-1:0] opNibble,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] operand
);
  localparam int NIB_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] loadValue;

  always_comb begin
    loadValue = strobes.mergeNibble ? {opNibble, rdData} : {{NIB_W{1'b0}}, rdData};
    busAddr   = strobes.selOperand ? operand : pcAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    operand <= '0;
    else if (strobes.loadOperand) operand <= loadValue;
  end

  assert_operand_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadOperand) |-> $stable(operand));

  assert_nibble_merge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadOperand && strobes.mergeNibble) |-> operand[ADDR_W-1:DATA_W] == $past(opNibble));

  assert_zero_extend_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadOperand && !strobes.mergeNibble) |-> operand[ADDR_W-1:DATA_W] == '0);
endmodule

// File: rtl/mcyc_bus_ctrl.sv
module mcyc_bus_ctrl
  import mcyc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int NIB_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        stepOh,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [NIB_W-1:0]  opNibble,
  input  logic [DATA_W-1:0] rdData,
  input  logic              waitLine,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRd,
  output logic              busWr,
  output logic              pcInc,
  output logic              irClear,
  output logic              repeatCycle,
  output logic [ADDR_W-1:0] operand
);
  dpStrobe_t strobes;

  mcyc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .stepOh      (stepOh),
    .kind        (cycKind_e'(kind)),
    .waitLine    (waitLine),
    .strobes     (strobes),
    .busRd       (busRd),
    .busWr       (busWr),
    .pcInc       (pcInc),
    .irClear     (irClear),
    .repeatCycle (repeatCycle)
  );

  mcyc_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pcAddr   (pcAddr),
    .opNibble (opNibble),
    .rdData   (rdData),
    .busAddr  (busAddr),
    .operand  (operand)
  );
endmodule

// File: tb/mcyc_bus_ctrl_bench.sv
`timescale 1ns/1ps
module mcyc_bus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  stepOh;
  logic [1:0]  kind;
  logic [19:0] pcAddr;
  logic [3:0]  opNibble;
  logic [15:0] rdData;
  logic        waitLine;
  logic [19:0] busAddr;
  logic        busRd, busWr, pcInc, irClear, repeatCycle;
  logic [19:0] operand;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [19:0] modelOp;
  bit          modelStall;

  always #10 clk = ~clk;

  mcyc_bus_ctrl u_mcyc_bus_ctrl (
    .clk(clk), .rstN(rstN), .stepOh(stepOh), .kind(kind), .pcAddr(pcAddr),
    .opNibble(opNibble), .rdData(rdData), .waitLine(waitLine),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .pcInc(pcInc),
    .irClear(irClear), .repeatCycle(repeatCycle), .operand(operand)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, "busRd", busRd, 0);
    check(req, "busWr", busWr, 0);
    check(req, "pcInc", pcInc, 0);
    check(req, "irClear", irClear, 0);
    check(req, "repeatCycle", repeatCycle, 0);
    check(req, "operand", operand, modelOp);
  endtask

  // One machine cycle; w holds WAIT per step (bit0 point, bit1 open, bit2 take).
  task automatic runCycle(input string tag, input logic [1:0] k, input logic [19:0] pc,
                          input logic [3:0] nib, input logic [15:0] dat, input logic [2:0] w);
    for (int s = 0; s < 3; s++) begin
      bit isFetch, isRead, win, waited;
      @(negedge clk);
      stepOh = 3'b001 << s; kind = k; pcAddr = pc; opNibble = nib; rdData = dat; waitLine = w[s];
      isFetch = (k == 2'b00) || (k == 2'b01);
      isRead  = (k != 2'b11);
      win     = isRead ? (s != 0) : (s == 1);
      waited  = modelStall || (win && w[s]);
      #8;
      check("R2", {tag, " busAddr"}, busAddr, isFetch ? pc : modelOp);
      check(waited ? "R6" : "R3", {tag, " busRd"}, busRd, isRead && s != 0 && !waited);
      check("R7", {tag, " busWr"}, busWr, !isRead && s == 1 && !waited);
      check(k == 2'b01 ? "R4" : "R5", {tag, " pcInc"}, pcInc, s == 2 && isFetch && !waited);
      check("R8", {tag, " irClear"}, irClear, s == 2 && !isFetch && !waited);
      check("R6", {tag, " repeatCycle"}, repeatCycle, s == 2 && waited);
      check("R6", {tag, " operand"}, operand, modelOp);
      @(posedge clk);
      if (s == 2 && isFetch && !waited)
        modelOp = (k == 2'b01) ? {nib, dat} : {4'h0, dat};
      modelStall = (s == 0) ? 1'b0 : waited;
    end
    @(negedge clk);
    stepOh = 3'b000; waitLine = 1'b0;
    #8;
    check(k == 2'b01 ? "R4" : (k == 2'b00 ? "R5" : "R8"), {tag, " operand after"}, operand, modelOp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; stepOh = 0; kind = 0; pcAddr = 0; opNibble = 0; rdData = 0; waitLine = 0;
    modelOp = 0; modelStall = 0;
    repeat (3) @(negedge clk);
    #8; checkIdle("R1");
    @(negedge clk); rstN = 1;
    #8; checkIdle("R1");

    runCycle("R4", 2'b01, 20'h00100, 4'hA, 16'h1234, 3'b000);
    runCycle("R5", 2'b00, 20'h00101, 4'hF, 16'hBEEF, 3'b000);
    runCycle("R8", 2'b10, 20'h00102, 4'h0, 16'h5555, 3'b000);
    runCycle("R8", 2'b11, 20'h00103, 4'h0, 16'h0000, 3'b000);
    runCycle("R6", 2'b01, 20'h00200, 4'h7, 16'hAAAA, 3'b010);
    runCycle("R9", 2'b01, 20'h00200, 4'h7, 16'h9ABC, 3'b000);
    runCycle("R6", 2'b10, 20'h00201, 4'h0, 16'h0001, 3'b100);
    runCycle("R9", 2'b10, 20'h00201, 4'h0, 16'h0001, 3'b000);
    runCycle("R7", 2'b11, 20'h00202, 4'h0, 16'h0000, 3'b010);
    runCycle("R9", 2'b11, 20'h00202, 4'h0, 16'h0000, 3'b000);
    runCycle("R10", 2'b10, 20'h00300, 4'h0, 16'h0000, 3'b001);
    runCycle("R10", 2'b11, 20'h00301, 4'h0, 16'h0000, 3'b101);
    runCycle("R10", 2'b00, 20'h00302, 4'h3, 16'h4321, 3'b001);
    runCycle("R6", 2'b00, 20'h00400, 4'h0, 16'h1111, 3'b100);
    runCycle("R6", 2'b00, 20'h00400, 4'h0, 16'h2222, 3'b110);
    runCycle("R9", 2'b00, 20'h00400, 4'h5, 16'h3333, 3'b000);
    runCycle("R2", 2'b11, 20'h0FFFF, 4'h0, 16'h0000, 3'b000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule